// File: doc/BRIEF.md
# Byte-Coherent Capture Value Register

This block is a 16-bit timer channel value register. An 8-bit register bus reaches it as a high byte and a low byte. With the capture-mode flag set, the register takes the counter value whenever a capture strobe arrives. With the flag clear, it holds a match value that the bus writes one byte at a time. A small channel control register sits beside it. That register holds the event flag, the interrupt enable, and two pairs of mode and edge/level selection bits. The block drives an interrupt request from the flag and the enable.

Software reads the 16-bit value as two separate byte accesses, so a capture could land between them. The block prevents a torn value with a read buffer. In capture mode, the first byte read takes a snapshot of the whole value. The opposite byte then comes from that snapshot. A control-register write drops the snapshot. While the debug-halt input is high, the latch state is frozen and reads return the live value, so a read pair that a halt interrupts still completes correctly afterwards.

Top module: `capval_reg`

## Requirements
- R1: Synchronous active-high reset clears the value, the control register, the event flag, the interrupt output and the read latch. The first byte read after reset therefore returns 8'h00.
- R2: When `cap_mode`=1 and `cap_stb`=1, the live value takes `cap_val` and the event flag (control bit 7) is set at the same clock edge. When `cap_mode`=0, `cap_stb` changes neither the value nor the flag.
- R3: When `cap_mode`=1, byte writes through `wr_hi`/`wr_lo` do not change the value.
- R4: When `cap_mode`=0, `wr_hi` loads `wr_data` into bits 15:8 and `wr_lo` loads it into bits 7:0, with no buffering. A read in the next cycle returns the new byte.
- R5: `ctl_q` has this layout: bit 7 event flag, bit 6 interrupt enable, bit 5 mode-select B, bit 4 mode-select A, bit 3 edge/level-select B, bit 2 edge/level-select A. Bits 1:0 always read 0. A `ctl_wr` loads bits 6:2 from `wr_data[6:2]`.
- R6: A `ctl_wr` with `wr_data[7]`=0 clears the event flag. A `ctl_wr` with `wr_data[7]`=1 leaves the flag unchanged. A capture in the same cycle as a clearing write leaves the flag set.
- R7: `irq` is 1 exactly when both the event flag and the interrupt enable are 1. Clearing the enable selects polling with `irq`=0.
- R8: In capture mode without debug-halt, the first byte read returns the live byte and snapshots all 16 bits. Later reads return the snapshot. A read of the opposite byte returns the snapshot and releases the latch, and a repeated read of the first byte keeps it. The next first read takes a fresh snapshot. `rd_hi` and `rd_lo` are never high together.
- R9: Any `ctl_wr` releases the latch, including during debug-halt and including when a byte read happens in the same cycle.
- R10: While `dbg_halt`=1, byte reads return the live value and leave the latch state as it was. A read pair that the halt interrupts completes from the snapshot after the halt ends.
- R11: With `cap_mode`=0, byte reads return the live value and do not change the latch state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_mode | input | 1 | 1 = input-capture mode, 0 = output (match) mode |
| cap_stb | input | 1 | Capture event strobe |
| cap_val | input | 16 | Counter value taken on a capture |
| dbg_halt | input | 1 | Debug halt active |
| rd_hi | input | 1 | Read strobe for the high value byte |
| rd_lo | input | 1 | Read strobe for the low value byte |
| wr_hi | input | 1 | Write strobe for the high value byte |
| wr_lo | input | 1 | Write strobe for the low value byte |
| ctl_wr | input | 1 | Write strobe for the control register |
| wr_data | input | 8 | Bus write data |
| rd_data | output | 8 | Value byte selected by the read strobe (combinational) |
| ctl_q | output | 8 | Control register contents |
| irq | output | 1 | Channel interrupt request |

## Verification
The case that matters most is a capture strobe in the same cycle as a byte read. The first read must return the old live byte and snapshot the old value while the live register takes the new one. The second read must still return the old value's other half. The bench provokes this on every pass of a sweep over captured values and both read orders. It computes each expected byte arithmetically from the values it captured. A second collision, a capture together with a flag-clearing control write, is judged by whether the flag is still set one cycle later.

// File: rtl/capval_pkg.sv
package capval_pkg;

   localparam int CTL_W = 8;

   typedef struct packed {
      logic flag;
      logic ie;
      logic msel_b;
      logic msel_a;
      logic esel_b;
      logic esel_a;
   } chctl_t;

   function automatic logic [CTL_W-1:0] pack_ctl(input chctl_t c);
      return {c.flag, c.ie, c.msel_b, c.msel_a, c.esel_b, c.esel_a, 2'b00};
   endfunction

endpackage

// File: rtl/capval_ctl.sv
module capval_ctl
   import capval_pkg::*;
#(
   parameter int BUS_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             cap_set,
   input  logic             ctl_wr,
   input  logic [5:0]       ctl_bits,
   output logic [BUS_W-1:0] ctl_q,
   output logic             irq
);

   chctl_t r_ctl;

   always_ff @(posedge clk) begin
      if (rst) begin
         r_ctl <= '0;
      end else begin
         if (ctl_wr) begin
            r_ctl.ie     <= ctl_bits[4];
            r_ctl.msel_b <= ctl_bits[3];
            r_ctl.msel_a <= ctl_bits[2];
            r_ctl.esel_b <= ctl_bits[1];
            r_ctl.esel_a <= ctl_bits[0];
            if (!ctl_bits[5]) r_ctl.flag <= 1'b0;
         end
         if (cap_set) r_ctl.flag <= 1'b1;
      end
   end

   always_comb begin
      ctl_q            = '0;
      ctl_q[CTL_W-1:0] = pack_ctl(r_ctl);
   end

   assign irq = r_ctl.flag & r_ctl.ie;

   AST_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
      cap_set |=> ctl_q[7]); // R2
   AST_FLAG_KEEP: assert property (@(posedge clk) disable iff (rst)
      (ctl_wr && ctl_bits[5] && ctl_q[7]) |=> ctl_q[7]); // R6
   AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
      (ctl_wr && !ctl_bits[4]) |=> !irq); // R7

endmodule

// File: rtl/capval_store.sv
module capval_store #(
   parameter int VAL_W = 16,
   parameter int BUS_W = 8
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    cap_mode,
   input  logic                    cap_stb,
   input  logic [VAL_W-1:0]        cap_val,
   input  logic [VAL_W/BUS_W-1:0]  wr_en,
   input  logic [BUS_W-1:0]        wr_data,
   output logic [VAL_W-1:0]        live
);

   localparam int NB = VAL_W / BUS_W;

   for (genvar b = 0; b < NB; b++) begin : g_lane
      always_ff @(posedge clk) begin
         if (rst) begin
            live[b*BUS_W +: BUS_W] <= '0;
         end else if (cap_mode && cap_stb) begin
            live[b*BUS_W +: BUS_W] <= cap_val[b*BUS_W +: BUS_W];
         end else if (!cap_mode && wr_en[b]) begin
            live[b*BUS_W +: BUS_W] <= wr_data;
         end
      end
   end

   AST_CAP_LOAD: assert property (@(posedge clk) disable iff (rst)
      (cap_mode && cap_stb) |=> live == $past(cap_val)); // R2
   AST_CAP_NOWRITE: assert property (@(posedge clk) disable iff (rst)
      (cap_mode && !cap_stb) |=> $stable(live)); // R3
   AST_OUT_NOCAP: assert property (@(posedge clk) disable iff (rst)
      (!cap_mode && wr_en == '0) |=> $stable(live)); // R4

endmodule

// File: rtl/capval_coh.sv
module capval_coh #(
   parameter int VAL_W    = 16,
   parameter int BUS_W    = 8,
   parameter bit COHERENT = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             cap_mode,
   input  logic             dbg_halt,
   input  logic             rd_hi,
   input  logic             rd_lo,
   input  logic             ctl_wr,
   input  logic [VAL_W-1:0] live,
   output logic [BUS_W-1:0] rd_data
);

   localparam int HI_LSB = VAL_W - BUS_W;

   if (COHERENT) begin : g_buf
      logic             held;
      logic             held_hi;
      logic [VAL_W-1:0] snap;
      logic [VAL_W-1:0] src;
      logic             rd_act;

      assign rd_act = cap_mode && !dbg_halt && (rd_hi || rd_lo);

      always_ff @(posedge clk) begin
         if (rst) begin
            held    <= 1'b0;
            held_hi <= 1'b0;
            snap    <= '0;
         end else if (ctl_wr) begin
            held <= 1'b0;
         end else if (rd_act) begin
            if (!held) begin
               held    <= 1'b1;
               held_hi <= rd_hi;
               snap    <= live;
            end else if (rd_hi != held_hi) begin
               held <= 1'b0;
            end
         end
      end

      assign src     = (cap_mode && !dbg_halt && held) ? snap : live;
      assign rd_data = rd_hi ? src[HI_LSB +: BUS_W] : src[BUS_W-1:0];

      AST_CTL_UNLATCH: assert property (@(posedge clk) disable iff (rst)
         ctl_wr |=> !held); // R9
      AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (rst)
         (dbg_halt && !ctl_wr) |=> held == $past(held)); // R10
      AST_SNAP_HOLD: assert property (@(posedge clk) disable iff (rst)
         held |=> $stable(snap)); // R8
      AST_OUTMODE_KEEP: assert property (@(posedge clk) disable iff (rst)
         (!cap_mode && !ctl_wr) |=> held == $past(held)); // R11
   end else begin : g_direct
      assign rd_data = rd_hi ? live[HI_LSB +: BUS_W] : live[BUS_W-1:0];
   end

endmodule

// File: rtl/capval_reg.sv
module capval_reg
   import capval_pkg::*;
#(
   parameter int VAL_W    = 16,
   parameter int BUS_W    = 8,
   parameter bit COHERENT = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             cap_mode,
   input  logic             cap_stb,
   input  logic [VAL_W-1:0] cap_val,
   input  logic             dbg_halt,
   input  logic             rd_hi,
   input  logic             rd_lo,
   input  logic             wr_hi,
   input  logic             wr_lo,
   input  logic             ctl_wr,
   input  logic [BUS_W-1:0] wr_data,
   output logic [BUS_W-1:0] rd_data,
   output logic [BUS_W-1:0] ctl_q,
   output logic             irq
);

   localparam int NB = VAL_W / BUS_W;

   if (VAL_W != 2 * BUS_W) begin : g_bad_width
      $error("capval_reg: VAL_W must be exactly two bus bytes");
   end
   if (BUS_W < CTL_W) begin : g_bad_bus
      $error("capval_reg: bus narrower than the control register");
   end

   logic [VAL_W-1:0] live;
   logic [NB-1:0]    wr_en;

   assign wr_en = {wr_hi, wr_lo};

   capval_store #(.VAL_W(VAL_W), .BUS_W(BUS_W)) u_store (
      .clk      (clk),
      .rst      (rst),
      .cap_mode (cap_mode),
      .cap_stb  (cap_stb),
      .cap_val  (cap_val),
      .wr_en    (wr_en),
      .wr_data  (wr_data),
      .live     (live)
   );

   capval_coh #(.VAL_W(VAL_W), .BUS_W(BUS_W), .COHERENT(COHERENT)) u_coh (
      .clk      (clk),
      .rst      (rst),
      .cap_mode (cap_mode),
      .dbg_halt (dbg_halt),
      .rd_hi    (rd_hi),
      .rd_lo    (rd_lo),
      .ctl_wr   (ctl_wr),
      .live     (live),
      .rd_data  (rd_data)
   );

   capval_ctl #(.BUS_W(BUS_W)) u_ctl (
      .clk      (clk),
      .rst      (rst),
      .cap_set  (cap_mode && cap_stb),
      .ctl_wr   (ctl_wr),
      .ctl_bits (wr_data[7:2]),
      .ctl_q    (ctl_q),
      .irq      (irq)
   );

   AST_ONE_READ: assert property (@(posedge clk) disable iff (rst)
      !(rd_hi && rd_lo)); // R8
   AST_RESET_CLEAR: assert property (@(posedge clk)
      rst |=> (ctl_q == '0 && !irq)); // R1

endmodule

// File: tb/sim_capval_reg.sv
`timescale 1ns/1ps
module sim_capval_reg;

   logic        clk = 1'b0;
   logic        rst;
   logic        cap_mode, cap_stb, dbg_halt;
   logic [15:0] cap_val;
   logic        rd_hi, rd_lo, wr_hi, wr_lo, ctl_wr;
   logic [7:0]  wr_data;
   logic [7:0]  rd_data, ctl_q;
   logic        irq;
   int          n_chk = 0;
   int          n_fail = 0;

   always #2 clk = ~clk;

   capval_reg u0 (
      .clk(clk), .rst(rst), .cap_mode(cap_mode), .cap_stb(cap_stb),
      .cap_val(cap_val), .dbg_halt(dbg_halt), .rd_hi(rd_hi), .rd_lo(rd_lo),
      .wr_hi(wr_hi), .wr_lo(wr_lo), .ctl_wr(ctl_wr), .wr_data(wr_data),
      .rd_data(rd_data), .ctl_q(ctl_q), .irq(irq)
   );

   function automatic logic [7:0] bsel(input logic [15:0] v, input bit hi);
      return hi ? v[15:8] : v[7:0];
   endfunction

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      #1;
      cap_stb = 0; rd_hi = 0; rd_lo = 0; wr_hi = 0; wr_lo = 0; ctl_wr = 0;
   endtask

   task automatic cap(input logic [15:0] v);
      cap_stb = 1; cap_val = v; step();
   endtask

   task automatic wctl(input logic [7:0] d);
      ctl_wr = 1; wr_data = d; step();
   endtask

   task automatic wbyte(input bit hi, input logic [7:0] d);
      wr_hi = hi; wr_lo = !hi; wr_data = d; step();
   endtask

   // read one byte, optionally with a capture in the same cycle
   task automatic rd(input bit hi, input bit cs, input logic [15:0] cv,
                     input logic [7:0] exp, input string req);
      rd_hi = hi; rd_lo = !hi; cap_stb = cs; cap_val = cv;
      #1;
      chk(req, {8'h00, rd_data}, {8'h00, exp});
      step();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      rst = 1; cap_mode = 0; cap_stb = 0; cap_val = 0; dbg_halt = 0;
      rd_hi = 0; rd_lo = 0; wr_hi = 0; wr_lo = 0; ctl_wr = 0; wr_data = 0;
      repeat (3) @(posedge clk);
      #1 rst = 0;

      // R1: reset state
      chk("R1", {8'h00, ctl_q}, 16'h0000);
      chk("R1", {15'h0, irq}, 16'h0000);
      cap_mode = 1;
      rd(1, 0, 0, 8'h00, "R1");
      rd(0, 0, 0, 8'h00, "R1");

      // R2: capture sets value and flag together
      cap(16'hA55A);
      chk("R2", {15'h0, ctl_q[7]}, 16'h0001);
      rd(1, 0, 0, 8'hA5, "R2");
      rd(0, 0, 0, 8'h5A, "R2");

      // R3: byte writes ignored in capture mode
      wbyte(1, 8'hFF);
      wbyte(0, 8'h00);
      rd(1, 0, 0, 8'hA5, "R3");
      rd(0, 0, 0, 8'h5A, "R3");

      // R8: coherency sweep, capture colliding with first read
      for (int i = 0; i < 16; i++) begin
         for (int o = 0; o < 2; o++) begin
            logic [15:0] v1, v2;
            bit f;
            v1 = (16'(i) * 16'h1357) ^ 16'h00F0;
            v2 = ~v1;
            f  = (o == 0);
            cap(v1);
            rd(f,  1, v2, bsel(v1, f),  "R8");
            rd(!f, 0, 0,  bsel(v1, !f), "R8");
            rd(f,  0, 0,  bsel(v2, f),  "R8");
            rd(f,  1, v1, bsel(v2, f),  "R8");
            rd(!f, 0, 0,  bsel(v2, !f), "R8");
            rd(f,  0, 0,  bsel(v1, f),  "R8");
            rd(!f, 0, 0,  bsel(v1, !f), "R8");
         end
      end

      // R10: debug halt bypasses and freezes the latch
      cap(16'h1234);
      rd(1, 0, 0, 8'h12, "R10");
      cap(16'hABCD);
      dbg_halt = 1;
      rd(0, 0, 0, 8'hCD, "R10");
      rd(1, 0, 0, 8'hAB, "R10");
      rd(0, 0, 0, 8'hCD, "R10");
      dbg_halt = 0;
      rd(0, 0, 0, 8'h34, "R10");
      rd(1, 0, 0, 8'hAB, "R10");
      rd(0, 0, 0, 8'hCD, "R10");

      // R9: control write releases the latch, with and without halt
      cap(16'h1111);
      rd(1, 0, 0, 8'h11, "R9");
      cap(16'h2222);
      wctl(8'h80);
      rd(0, 0, 0, 8'h22, "R9");
      rd(1, 0, 0, 8'h22, "R9");
      cap(16'h3333);
      rd(0, 0, 0, 8'h33, "R9");
      cap(16'h4444);
      dbg_halt = 1;
      wctl(8'h80);
      dbg_halt = 0;
      rd(1, 0, 0, 8'h44, "R9");
      rd(0, 0, 0, 8'h44, "R9");

      // R11: output-mode reads are live and leave the latch alone
      cap(16'h5566);
      rd(1, 0, 0, 8'h55, "R11");
      cap_mode = 0;
      wbyte(0, 8'h77);
      rd(0, 0, 0, 8'h77, "R11");
      rd(1, 0, 0, 8'h55, "R11");
      cap_mode = 1;
      rd(0, 0, 0, 8'h66, "R11");

      // R4: direct byte writes in output mode, swept over all byte values
      cap_mode = 0;
      for (int d = 0; d < 256; d++) begin
         wbyte(1, 8'(d));
         wbyte(0, ~8'(d));
         rd(1, 0, 0, 8'(d),  "R4");
         rd(0, 0, 0, ~8'(d), "R4");
      end

      // R2: capture strobe ignored in output mode
      wctl(8'h00);
      cap(16'hFFFF);
      chk("R2", {15'h0, ctl_q[7]}, 16'h0000);
      rd(1, 0, 0, 8'hFF, "R2");
      rd(0, 0, 0, 8'h00, "R2");

      // R6: flag clear rules and collision with a capture
      cap_mode = 1;
      cap_stb = 1; cap_val = 16'h0F0F; ctl_wr = 1; wr_data = 8'h00; step();
      chk("R6", {15'h0, ctl_q[7]}, 16'h0001);
      wctl(8'h80);
      chk("R6", {15'h0, ctl_q[7]}, 16'h0001);
      wctl(8'h00);
      chk("R6", {15'h0, ctl_q[7]}, 16'h0000);

      // R5, R7: control register sweep with the flag set beforehand
      for (int d = 0; d < 256; d++) begin
         logic [7:0] dv;
         dv = 8'(d);
         cap(16'(d));
         wctl(dv);
         chk("R5", {8'h00, ctl_q}, {8'h00, (dv & 8'hFC)});
         chk("R7", {15'h0, irq}, {15'h0, (dv[7] & dv[6])});
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule